// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block keeps the four 16-bit words that describe a network controller's interrupt state: a control/status word, a mask word and two extended status words. Software reaches them through a single-address register port. Status bits are set by one-cycle event pulses from the data path and are cleared by writing a one to them. The block folds all pending, unmasked sources into a summary flag, which is readable as bit 7 of the control word. It drives an interrupt line when that flag is up and the global enable is on.

The first extended word pairs each of four status bits with a suppress bit sitting directly below it. The second extended word pairs two status bits with an enable bit directly below each. The first extended word also carries a software interrupt: a request bit that turns into a sticky acknowledge bit as soon as the global enable is on, and that acknowledge bit raises the interrupt by itself.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the control word (address 0) reads 0x0004 and the mask word (address 1), first extended word (address 2) and second extended word (address 3) read 0x0000; irq_o is low.
- R2: In the control word, bits 8–12 and 14 (0x5F00) are cleared by writing a one and kept by writing a zero. Bit 7 reads back the summary flag and ignores writes. All other bits, including the global enable at bit 6, take the written value.
- R3: The mask word reads back exactly what was last written to it.
- R4: The summary flag is set when any control bit in 0x5F00 is set while the mask bit at the same position is clear.
- R5: In the first extended word, the pair at k = 0, 2, 4, 8 raises the summary flag when bit k+1 is set and bit k is clear.
- R6: In the second extended word, the pair at k = 8, 10 raises the summary flag when bit k+1 and bit k are both set.
- R7: Writing a one clears the first extended word's bits in 0x026A and the second extended word's bits in 0x0A90. Writing a zero keeps those bits. All other bits take the written value.
- R8: When first-extended bit 7 (request) is set while control bit 6 (global enable) is set, the request is cleared and bit 6 (acknowledge) is set in the same update. A set acknowledge bit raises the summary flag.
- R9: irq_o is high exactly when the summary flag is set and control bit 6 is set.
- R10: Event inputs set only the clear-on-one bits of their word (0x5F00, 0x026A, 0x0A90). Event bits at any other position have no effect.
- R11: An event on a bit in the same cycle as a write of one to that bit leaves the bit set.
- R12: A write or an event takes effect at the next rising clock edge, and the summary flag and irq_o follow at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the word selected by addr |
| addr | input | 2 | Word select for both writes and reads (0 control, 1 mask, 2 first extended, 3 second extended) |
| wr_data | input | 16 | Write data |
| ev_ctrl | input | 16 | One-cycle event pulses for the control word |
| ev_exta | input | 16 | One-cycle event pulses for the first extended word |
| ev_extb | input | 16 | One-cycle event pulses for the second extended word |
| rd_data | output | 16 | Read data of the word selected by addr |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every control status bit against its mask and every extended pair across all four status/enable combinations. A design with the sense of one pair inverted, or with a wrong mask position, raises or misses irq_o in one of those cells. Writes of all ones over fully set words catch a wrong clear-on-one mask, which shows up as bits that stick or bits that follow the data. The bench also sets the software request with the enable off and then turns the enable on. A design that converts the request too early, or never, gives the wrong acknowledge timing. Finally, an event that coincides with a clearing write exposes a design that lets the write win.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int unsigned DW   = 16;
  localparam int unsigned NREG = 4;
  localparam int unsigned AW   = $clog2(NREG);

  typedef enum logic [AW-1:0] {
    RA_CTRL = 2'd0,
    RA_MASK = 2'd1,
    RA_EXTA = 2'd2,
    RA_EXTB = 2'd3
  } reg_addr_e;

  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned GIE_BIT  = 6;
  localparam int unsigned UREQ_BIT = 7;
  localparam int unsigned UACK_BIT = 6;

  localparam logic [DW-1:0] CTRL_RST  = 16'h0004;
  localparam logic [DW-1:0] CTRL_W1C  = 16'h5F00;
  localparam logic [DW-1:0] EXTA_W1C  = 16'h026A;
  localparam logic [DW-1:0] EXTA_PAIR = 16'h0115;
  localparam logic [DW-1:0] EXTB_W1C  = 16'h0A90;
  localparam logic [DW-1:0] EXTB_PAIR = 16'h0500;
  localparam logic [DW-1:0] ALL_ONES  = {DW{1'b1}};
  localparam logic [DW-1:0] CTRL_KEEP = ~(DW'(1) << FLAG_BIT);

  // per-word tables, index = word address
  localparam logic [NREG-1:0][DW-1:0] RST_TAB  = {16'h0000, 16'h0000, 16'h0000, CTRL_RST};
  localparam logic [NREG-1:0][DW-1:0] W1C_TAB  = {EXTB_W1C, EXTA_W1C, 16'h0000, CTRL_W1C};
  localparam logic [NREG-1:0][DW-1:0] KEEP_TAB = {ALL_ONES, ALL_ONES, ALL_ONES, CTRL_KEEP};

endpackage

// File: rtl/irqagg_rst_sync.sv
module irqagg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/irqagg_field.sv
// Next-state of one status word: clear-on-one bits, plain bits, event set.
module irqagg_field #(
  parameter int unsigned   WIDTH     = 16,
  parameter logic [WIDTH-1:0] W1C_MASK  = '0,
  parameter logic [WIDTH-1:0] KEEP_MASK = '1
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             wr_hit,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] evt,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] after_wr;

  always_comb begin
    if (wr_hit) after_wr = (wdata & ~W1C_MASK) | (cur & W1C_MASK & ~wdata);
    else        after_wr = cur;
    // events only reach clear-on-one bits and override a same-cycle clear
    nxt = (after_wr | (evt & W1C_MASK)) & KEEP_MASK;
  end
endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary
  import irqagg_pkg::*;
(
  input  logic [DW-1:0] ctrl,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] exta,
  input  logic [DW-1:0] extb,
  output logic          summary
);
  logic ctrl_hit, exta_hit, extb_hit;

  always_comb begin
    ctrl_hit = |(ctrl & ~mask & CTRL_W1C);
    exta_hit = (|((exta >> 1) & ~exta & EXTA_PAIR)) | exta[UACK_BIT];
    extb_hit = |((extb >> 1) & extb & EXTB_PAIR);
    summary  = ctrl_hit | exta_hit | extb_hit;
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irqagg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] ev_ctrl,
  input  logic [DW-1:0] ev_exta,
  input  logic [DW-1:0] ev_extb,
  output logic [DW-1:0] rd_data,
  output logic          irq_o
);
  logic                      rst_sync_n;
  logic [NREG-1:0][DW-1:0]   reg_q, fld_nxt, reg_d, evt_arr;
  logic                      flag_q, flag_d, upd;

  irqagg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sync_n)
  );

  always_comb begin
    evt_arr          = '0;
    evt_arr[RA_CTRL] = ev_ctrl;
    evt_arr[RA_EXTA] = ev_exta;
    evt_arr[RA_EXTB] = ev_extb;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_word
    irqagg_field #(
      .WIDTH(DW), .W1C_MASK(W1C_TAB[i]), .KEEP_MASK(KEEP_TAB[i])
    ) u_fld (
      .cur(reg_q[i]),
      .wr_hit(wr_en && (addr == AW'(i))),
      .wdata(wr_data),
      .evt(evt_arr[i]),
      .nxt(fld_nxt[i])
    );
  end

  // software interrupt: a request under global enable becomes an acknowledge
  always_comb begin
    reg_d = fld_nxt;
    if (fld_nxt[RA_EXTA][UREQ_BIT] && fld_nxt[RA_CTRL][GIE_BIT]) begin
      reg_d[RA_EXTA][UREQ_BIT] = 1'b0;
      reg_d[RA_EXTA][UACK_BIT] = 1'b1;
    end
  end

  irqagg_summary u_sum (
    .ctrl(reg_d[RA_CTRL]), .mask(reg_d[RA_MASK]),
    .exta(reg_d[RA_EXTA]), .extb(reg_d[RA_EXTB]),
    .summary(flag_d)
  );

  assign upd = wr_en | (|ev_ctrl) | (|ev_exta) | (|ev_extb);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      reg_q  <= RST_TAB;
      flag_q <= 1'b0;
    end else if (upd) begin
      reg_q  <= reg_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data = reg_q[addr];
    if (addr == RA_CTRL) rd_data[FLAG_BIT] = flag_q;
  end

  assign irq_o = flag_q & reg_q[RA_CTRL][GIE_BIT];
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] ev_ctrl,
  input logic [DW-1:0] ev_exta,
  input logic [DW-1:0] ev_extb,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] exta_q,
  input logic          irq_o
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R11: an event bit on a clear-on-one position is set after the edge
  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((exta_q & $past(ev_exta) & EXTA_W1C) == ($past(ev_exta) & EXTA_W1C)));

  // R2: a write of one to a control status bit clears it unless an event hit it
  a_r2_ctrl_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en && addr == RA_CTRL))
      |-> ((ctrl_q & CTRL_W1C & $past(wr_data & ~ev_ctrl)) == '0));

  // R7: same for the first extended word, acknowledge bit excluded
  a_r7_exta_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en && addr == RA_EXTA))
      |-> ((exta_q & EXTA_W1C & ~(DW'(1) << UACK_BIT) & $past(wr_data & ~ev_exta)) == '0));

  // R9: the interrupt line never rises without the global enable
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl_q[GIE_BIT]);

  // R8: a request never stays pending while the global enable is on
  a_r8_req_converted: assert property (@(posedge clk) disable iff (!rst_n)
    !(exta_q[UREQ_BIT] && ctrl_q[GIE_BIT]));

  // R12: with no write and no event, state and output hold
  a_r12_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!wr_en && ev_ctrl == '0 && ev_exta == '0 && ev_extb == '0))
      |-> ($stable(ctrl_q) && $stable(exta_q) && $stable(irq_o)));
endmodule

bind irq_status_agg irqagg_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .ev_ctrl(ev_ctrl), .ev_exta(ev_exta), .ev_extb(ev_extb),
  .ctrl_q(reg_q[0]), .exta_q(reg_q[2]), .irq_o(irq_o)
);

// File: tb/irq_status_agg_test.sv
`timescale 1ns/100ps
module irq_status_agg_test;
  logic        clk, rst_n, wr_en;
  logic [1:0]  addr;
  logic [15:0] wr_data, ev_ctrl, ev_exta, ev_extb, rd_data;
  logic        irq_o;

  int n_chk, n_fail;
  logic finished;

  // bench-side expected state
  logic [15:0] m_ctrl, m_mask, m_a, m_b;
  logic        m_flag;

  irq_status_agg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ev_ctrl(ev_ctrl), .ev_exta(ev_exta), .ev_extb(ev_extb),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // clear-on-one words: W1C bits clear on written one, others take data,
  // events set W1C bits only and win over a same-cycle clear
  function automatic logic [15:0] nxt(input logic [15:0] cur, input logic hit,
      input logic [15:0] d, input logic [15:0] ev, input logic [15:0] w1c);
    logic [15:0] w;
    w = hit ? ((d & ~w1c) | (cur & w1c & ~d)) : cur;
    return w | (ev & w1c);
  endfunction

  task automatic op(input logic w, input logic [1:0] a, input logic [15:0] d,
                    input logic [15:0] ec, input logic [15:0] ea, input logic [15:0] eb);
    @(negedge clk);
    wr_en = w; addr = a; wr_data = d; ev_ctrl = ec; ev_exta = ea; ev_extb = eb;
    @(negedge clk);
    wr_en = 1'b0; ev_ctrl = '0; ev_exta = '0; ev_extb = '0;
    m_ctrl = nxt(m_ctrl, w && a == 2'd0, d, ec, 16'h5F00) & 16'hFF7F;
    m_mask = nxt(m_mask, w && a == 2'd1, d, 16'h0, 16'h0000);
    m_a    = nxt(m_a,    w && a == 2'd2, d, ea, 16'h026A);
    m_b    = nxt(m_b,    w && a == 2'd3, d, eb, 16'h0A90);
    if (m_a[7] && m_ctrl[6]) begin m_a[7] = 1'b0; m_a[6] = 1'b1; end
    m_flag = ((m_ctrl & ~m_mask & 16'h5F00) != 0)
           || (m_a[1] && !m_a[0]) || (m_a[3] && !m_a[2]) || (m_a[5] && !m_a[4])
           || (m_a[9] && !m_a[8]) || m_a[6]
           || (m_b[9] && m_b[8]) || (m_b[11] && m_b[10]);
  endtask

  task automatic check_all(input string tag);
    addr = 2'd0; #0.4; check({tag, " ctrl"}, rd_data, m_ctrl | (16'(m_flag) << 7));
    addr = 2'd1; #0.4; check({tag, " mask"}, rd_data, m_mask);
    addr = 2'd2; #0.4; check({tag, " exta"}, rd_data, m_a);
    addr = 2'd3; #0.4; check({tag, " extb"}, rd_data, m_b);
    check({tag, " irq"}, 16'(irq_o), 16'(m_flag && m_ctrl[6]));
  endtask

  initial begin
    finished = 1'b0;
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    ev_ctrl = '0; ev_exta = '0; ev_extb = '0;
    m_ctrl = 16'h0004; m_mask = '0; m_a = '0; m_b = '0; m_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");

    // R3 mask read-back and R2 plain control bits
    for (int b = 0; b < 16; b++) begin
      op(1'b1, 2'd1, 16'h1 << b, '0, '0, '0);
      check_all("R3 mask walk");
    end
    op(1'b1, 2'd1, 16'hFFFF, '0, '0, '0);
    op(1'b1, 2'd0, 16'h00BF, '0, '0, '0);
    check_all("R2 plain bits and read-only flag");
    op(1'b1, 2'd1, 16'h0000, '0, '0, '0);
    op(1'b1, 2'd0, 16'h0040, '0, '0, '0);
    check_all("R2 enable only");

    // R4 / R9 control status against mask, with enable on and off
    for (int b = 8; b < 15; b++) begin
      if (b == 13) continue;
      for (int g = 0; g < 2; g++) begin
        op(1'b1, 2'd0, g ? 16'h0040 : 16'h0000, '0, '0, '0);
        op(1'b0, 2'd0, '0, 16'h1 << b, '0, '0);
        check_all("R4 R9 R10 status set");
        op(1'b1, 2'd1, 16'h1 << b, '0, '0, '0);
        check_all("R4 masked");
        op(1'b1, 2'd1, 16'h0000, '0, '0, '0);
        check_all("R4 unmasked");
        op(1'b1, 2'd0, (g ? 16'h0040 : 16'h0000) | (16'h1 << b), '0, '0, '0);
        check_all("R2 R12 clear on one");
      end
    end
    op(1'b1, 2'd0, 16'h0040, '0, '0, '0);

    // R5 first extended pairs: all status/enable combinations
    for (int i = 0; i < 4; i++) begin
      int k;
      k = (i == 3) ? 8 : 2 * i;
      for (int e = 0; e < 2; e++) begin
        op(1'b1, 2'd2, e ? (16'h1 << k) : 16'h0, '0, '0, '0);
        check_all("R5 enable only");
        op(1'b0, 2'd0, '0, '0, 16'h1 << (k + 1), '0);
        check_all("R5 status");
        op(1'b1, 2'd2, 16'h1 << (k + 1), '0, '0, '0);
        check_all("R5 R7 cleared");
      end
    end

    // R6 second extended pairs
    for (int i = 0; i < 2; i++) begin
      int k;
      k = 8 + 2 * i;
      for (int e = 0; e < 2; e++) begin
        op(1'b1, 2'd3, e ? (16'h1 << k) : 16'h0, '0, '0, '0);
        op(1'b0, 2'd0, '0, '0, '0, 16'h1 << (k + 1));
        check_all("R6 pair");
        op(1'b1, 2'd3, 16'h1 << (k + 1), '0, '0, '0);
        check_all("R6 R7 cleared");
      end
    end

    // R10 out-of-mask event bits ignored; R7 full clear with data bits
    op(1'b1, 2'd2, 16'h0000, '0, '0, '0);
    op(1'b1, 2'd3, 16'h0000, '0, '0, '0);
    op(1'b0, 2'd0, '0, 16'hFFFF, 16'hFF7F, 16'hFFFF);
    check_all("R10 event masks");
    op(1'b1, 2'd2, 16'hFF7F, '0, '0, '0);
    check_all("R7 first extended all ones");
    op(1'b1, 2'd3, 16'hFFFF, '0, '0, '0);
    check_all("R7 second extended all ones");
    op(1'b1, 2'd0, 16'h5F40, '0, '0, '0);
    op(1'b1, 2'd2, 16'h0000, '0, '0, '0);
    op(1'b1, 2'd3, 16'h0000, '0, '0, '0);
    check_all("R2 R7 back to idle");

    // R8 software request, enable off then on
    op(1'b1, 2'd0, 16'h0000, '0, '0, '0);
    op(1'b1, 2'd2, 16'h0080, '0, '0, '0);
    check_all("R8 request held with enable off");
    op(1'b1, 2'd0, 16'h0040, '0, '0, '0);
    check_all("R8 converted to acknowledge");
    op(1'b1, 2'd2, 16'h0040, '0, '0, '0);
    check_all("R8 acknowledge cleared");
    op(1'b1, 2'd2, 16'h0080, '0, '0, '0);
    check_all("R8 immediate conversion");
    op(1'b1, 2'd2, 16'h0040, '0, '0, '0);

    // R11 event and clearing write in the same cycle
    op(1'b0, 2'd0, '0, 16'h0100, '0, '0);
    op(1'b1, 2'd0, 16'h0140, 16'h0100, '0, '0);
    check_all("R11 control event wins");
    op(1'b0, 2'd0, '0, '0, 16'h0008, '0);
    op(1'b1, 2'd2, 16'h0008, '0, 16'h0008, '0);
    check_all("R11 extended event wins");
    op(1'b1, 2'd0, 16'h0140, '0, '0, '0);
    op(1'b1, 2'd2, 16'h0008, '0, '0, '0);
    check_all("R12 final idle");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule